// File: doc/BRIEF.md
# One-Wire Bus Command Sequencer

This block is the master of a single open-drain one-wire bus. A host hands it one command at a time, together with a data byte and option bits, and the block then generates every slot on the bus by itself. The commands are a bus reset with presence detection, a byte write, a byte read, a single-bit slot and a search triplet. A triplet is two read slots followed by one write slot, and it makes one step of a device-address search. The host waits for `busy_o` to drop and then reads the results from the status outputs.

All slot timing counts a clock-enable tick (`tick_i`), which is nominally one microsecond. Each duration is a parameter for the standard speed and for the overdrive speed. The speed is chosen for each command. The block does not drive the bus pin itself. It outputs a pull-low enable (`drv_low_o`), an active-pullup enable (`apu_en_o`) and a strong-pullup enable (`spu_en_o`) for an external line driver. It reads back the bus level on `line_i` through a synchronizer.

Top module: `ow_seq`

## Requirements
- R1: Reset at standard speed: the bus is pulled low for 480 ticks. The block checks for a short 3 ticks after release and samples for presence 70 ticks after release. `busy_o` stays high until 410 ticks after release.
- R2: `presence_o` is 1 after a reset only when the bus is low at the presence sample point, no short was seen and masking is off. It is cleared when each reset command is accepted.
- R3: When `ppm_i` is set for a reset, `presence_o` stays 0 even if a device answers.
- R4: If the bus is low at the short check point, `short_o` becomes 1 and `presence_o` stays 0.
- R5: A byte write sends `wdata_i` least significant bit first. A 1 is a 6-tick low pulse and a 0 is a 60-tick low pulse, in slots of 70 ticks (standard speed).
- R6: A byte read makes 8 read slots, each a 1-slot with the bus sampled 9 ticks after the slot starts. `rdata_o` then holds the sampled bits, the first received bit in bit 0.
- R7: A single-bit command writes `wdata_i[0]` in one slot. `bit_o` then shows the bus level sampled in that slot.
- R8: A triplet makes two read slots, whose results go to `bit_o` and `cmp_o`, and then writes the direction bit `dir_o`. The direction equals `bit_o` when the two reads differ. It is the host direction `wdata_i[0]` when both reads are 0, and 1 when both are 1.
- R9: With `speed_od_i` set, the durations are: reset low 48, short check 2, presence sample 8, reset end 40 after release, 1-pulse 1, 0-pulse 8, sample 2, slot 10 ticks.
- R10: With `spu_i` set on a byte write or single-bit command, `spu_en_o` rises when the command ends. It stays high until the next accepted command, which clears it at the same edge that starts the new command. Read and reset commands never set it.
- R11: With `apu_i` set, `apu_en_o` is high for 2 ticks after each release of the bus by the block. It is never high while `drv_low_o` is high, and never high when `apu_i` was clear.
- R12: A command strobe while `busy_o` is high has no effect. So has a strobe with a command code above 4. The command codes are 0 reset, 1 byte write, 2 byte read, 3 single bit and 4 triplet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base clock enable, one tick per time unit |
| cmd_valid_i | input | 1 | Command strobe, taken when idle |
| cmd_i | input | 3 | Command code |
| wdata_i | input | 8 | Write byte; bit 0 is also the single-bit value and the host direction for a triplet |
| speed_od_i | input | 1 | 1 selects overdrive timing |
| apu_i | input | 1 | Active pullup for this command |
| spu_i | input | 1 | Strong pullup after this command |
| ppm_i | input | 1 | Mask presence for this reset |
| line_i | input | 1 | Sensed bus level |
| drv_low_o | output | 1 | Pull the bus low |
| apu_en_o | output | 1 | Active drive-high enable |
| spu_en_o | output | 1 | Strong pullup enable |
| busy_o | output | 1 | Command in progress |
| presence_o | output | 1 | Device presence seen in the last reset |
| short_o | output | 1 | Bus short seen in the last reset |
| bit_o | output | 1 | Single-bit result or first triplet read |
| cmp_o | output | 1 | Second triplet read |
| dir_o | output | 1 | Direction written in the last triplet |
| rdata_o | output | 8 | Byte received by the last byte read |

## Verification
The hardest situations to reach are the ones where the bus has to answer inside a narrow window of a slot the block is timing itself. Examples are a device holding the line low across the read sample point, a presence pulse that falls between the short check and the presence sample, or a line that is already low right after release. The bench uses a device model that watches `drv_low_o` and reacts to each falling edge. It measures each low pulse to tell writes from resets and decodes the written bits. It pulls the line from a scripted pattern, so each triplet case (01, 10, 00 with both host directions, 11) and each reset outcome can be set up on purpose.

// File: rtl/ow_seq_pkg.sv
package ow_seq_pkg;

    typedef enum logic [2:0] {
        CMD_RESET = 3'd0,
        CMD_WBYTE = 3'd1,
        CMD_RBYTE = 3'd2,
        CMD_BIT   = 3'd3,
        CMD_TRIP  = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RST,
        ST_SLOT
    } state_e;

    localparam int unsigned CMD_LAST = 4;

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= sr_d;
    end

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ow_tick_timer.sv
module ow_tick_timer #(
    parameter int W = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/ow_seq.sv
module ow_seq
    import ow_seq_pkg::*;
#(
    parameter int STD_RST_LOW  = 480,
    parameter int STD_RST_REST = 410,
    parameter int STD_PRES     = 70,
    parameter int STD_SHORT    = 3,
    parameter int STD_W1       = 6,
    parameter int STD_W0       = 60,
    parameter int STD_SAMP     = 9,
    parameter int STD_SLOT     = 70,
    parameter int OD_RST_LOW   = 48,
    parameter int OD_RST_REST  = 40,
    parameter int OD_PRES      = 8,
    parameter int OD_SHORT     = 2,
    parameter int OD_W1        = 1,
    parameter int OD_W0        = 8,
    parameter int OD_SAMP      = 2,
    parameter int OD_SLOT      = 10,
    parameter int APU_TICKS    = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       cmd_valid_i,
    input  logic [2:0] cmd_i,
    input  logic [7:0] wdata_i,
    input  logic       speed_od_i,
    input  logic       apu_i,
    input  logic       spu_i,
    input  logic       ppm_i,
    input  logic       line_i,
    output logic       drv_low_o,
    output logic       apu_en_o,
    output logic       spu_en_o,
    output logic       busy_o,
    output logic       presence_o,
    output logic       short_o,
    output logic       bit_o,
    output logic       cmp_o,
    output logic       dir_o,
    output logic [7:0] rdata_o
);
    localparam int CW = $clog2(STD_RST_LOW + STD_RST_REST + 1);
    localparam int AW = $clog2(APU_TICKS + 1);

    typedef struct packed {
        state_e        st;
        cmd_e          cmd;
        logic          od;
        logic          apu;
        logic          spu;
        logic          ppm;
        logic          hdir;
        logic          drv;
        logic [7:0]    sh;
        logic [3:0]    slot;
        logic          smp;
        logic          pres;
        logic          shrt;
        logic          bitr;
        logic          cmpr;
        logic          dir;
        logic          spu_on;
        logic [AW-1:0] apu_cnt;
    } regs_t;

    regs_t d, q;
    logic line_s, cnt_clr;
    logic [CW-1:0] cnt, tn;
    logic [CW-1:0] t_rlow, t_rrest, t_pres, t_short, t_w1, t_w0, t_samp, t_slot;
    logic wbit, done, cmd_ok;

    ow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s)
    );

    ow_tick_timer #(.W(CW)) u_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .tick_i(tick_i), .cnt_o(cnt)
    );

    assign cmd_ok = (32'(cmd_i) <= CMD_LAST);

    always_comb begin
        t_rlow  = q.od ? CW'(OD_RST_LOW)  : CW'(STD_RST_LOW);
        t_rrest = q.od ? CW'(OD_RST_REST) : CW'(STD_RST_REST);
        t_pres  = q.od ? CW'(OD_PRES)     : CW'(STD_PRES);
        t_short = q.od ? CW'(OD_SHORT)    : CW'(STD_SHORT);
        t_w1    = q.od ? CW'(OD_W1)       : CW'(STD_W1);
        t_w0    = q.od ? CW'(OD_W0)       : CW'(STD_W0);
        t_samp  = q.od ? CW'(OD_SAMP)     : CW'(STD_SAMP);
        t_slot  = q.od ? CW'(OD_SLOT)     : CW'(STD_SLOT);
    end

    always_comb begin
        d       = q;
        cnt_clr = 1'b0;
        done    = 1'b0;
        tn      = cnt + 1'b1;
        if (q.cmd == CMD_TRIP)       wbit = (q.slot == 4'd2) ? q.dir : 1'b1;
        else if (q.cmd == CMD_RBYTE) wbit = 1'b1;
        else                         wbit = q.sh[0];

        if (tick_i && q.apu_cnt != '0) d.apu_cnt = q.apu_cnt - 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid_i && cmd_ok) begin
                    d.cmd    = cmd_e'(cmd_i);
                    d.od     = speed_od_i;
                    d.apu    = apu_i;
                    d.spu    = spu_i;
                    d.ppm    = ppm_i;
                    d.hdir   = wdata_i[0];
                    d.sh     = wdata_i;
                    d.slot   = '0;
                    d.spu_on = 1'b0;
                    d.drv    = 1'b1;
                    cnt_clr  = 1'b1;
                    if (cmd_i == CMD_RESET) begin
                        d.st   = ST_RST;
                        d.pres = 1'b0;
                        d.shrt = 1'b0;
                    end else begin
                        d.st   = ST_SLOT;
                    end
                end
            end
            ST_RST: begin
                if (tick_i) begin
                    if (tn == t_rlow)           d.drv  = 1'b0;
                    if (tn == t_rlow + t_short) d.shrt = ~line_s;
                    if (tn == t_rlow + t_pres)  d.pres = ~line_s & ~q.ppm & ~q.shrt;
                    if (tn == t_rlow + t_rrest) d.st   = ST_IDLE;
                end
            end
            ST_SLOT: begin
                if (tick_i) begin
                    if (tn == (wbit ? t_w1 : t_w0)) d.drv = 1'b0;
                    if (tn == t_samp)               d.smp = line_s;
                    if (tn == t_slot) begin
                        cnt_clr = 1'b1;
                        d.slot  = q.slot + 1'b1;
                        d.sh    = {q.smp, q.sh[7:1]};
                        unique case (q.cmd)
                            CMD_BIT: begin
                                d.bitr = q.smp;
                                done   = 1'b1;
                            end
                            CMD_TRIP: begin
                                if (q.slot == 4'd0) d.bitr = q.smp;
                                if (q.slot == 4'd1) begin
                                    d.cmpr = q.smp;
                                    d.dir  = (q.bitr != q.smp) ? q.bitr
                                           : (q.bitr ? 1'b1 : q.hdir);
                                end
                                done = (q.slot == 4'd2);
                            end
                            default: done = (q.slot == 4'd7);
                        endcase
                        if (done) begin
                            d.st     = ST_IDLE;
                            d.spu_on = q.spu & ((q.cmd == CMD_WBYTE) || (q.cmd == CMD_BIT));
                        end else begin
                            d.drv    = 1'b1;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (q.drv && !d.drv && q.apu) d.apu_cnt = AW'(APU_TICKS);
        if (d.drv)                    d.apu_cnt = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.cmd <= CMD_RESET;
        end else begin
            q <= d;
        end
    end

    assign drv_low_o  = q.drv;
    assign apu_en_o   = (q.apu_cnt != '0);
    assign spu_en_o   = q.spu_on;
    assign busy_o     = (q.st != ST_IDLE);
    assign presence_o = q.pres;
    assign short_o    = q.shrt;
    assign bit_o      = q.bitr;
    assign cmp_o      = q.cmpr;
    assign dir_o      = q.dir;
    assign rdata_o    = q.sh;

    // R1
    rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(drv_low_o) && q.st == ST_RST) |-> (cnt == t_rlow));

    // R3
    ppm_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(presence_o) |-> !q.ppm);

    // R8
    trip_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_SLOT && q.cmd == CMD_TRIP && q.slot == 4'd2 && bit_o != cmp_o)
            |-> (dir_o == bit_o));

    // R10
    spu_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(spu_en_o) |-> $past(busy_o));

    // R10
    spu_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (spu_en_o && cmd_valid_i && cmd_ok && !busy_o) |=> (!spu_en_o && drv_low_o));

    // R11
    pull_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(drv_low_o && (apu_en_o || spu_en_o)));

    // R12
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> ($stable(q.cmd) && $stable(q.od) && $stable(q.ppm)));
endmodule

// File: tb/sim_ow_seq.sv
`timescale 1ns/1ps
module sim_ow_seq;
    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic tick_i = 1'b0;
    logic cmd_valid_i = 1'b0;
    logic [2:0] cmd_i = '0;
    logic [7:0] wdata_i = '0;
    logic speed_od_i = 1'b0, apu_i = 1'b0, spu_i = 1'b0, ppm_i = 1'b0;
    logic line_i;
    logic drv_low_o, apu_en_o, spu_en_o, busy_o, presence_o, short_o, bit_o, cmp_o, dir_o;
    logic [7:0] rdata_o;

    int n_chk = 0, n_fail = 0;
    int tdiv = 0;

    // device model controls (written only by tasks)
    logic sl_present = 1'b0, sl_short = 1'b0, sl_od = 1'b0;
    logic [7:0] sl_pat = 8'hFF;
    int sl_base = 0;

    // device model state (written only by the model)
    int lowcnt = 0, last_low = 0, slots = 0, hold = 0, prs_cnt = 0;
    logic prs = 1'b0;
    logic [7:0] rx = '0;
    int apu_cyc = 0, overlap = 0;
    logic slave_low;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= (tdiv + 1) % 4;
        tick_i <= (tdiv == 3);
    end

    assign slave_low = (hold != 0) || sl_short ||
        (prs && prs_cnt >= (sl_od ? 12 : 80) && prs_cnt < (sl_od ? 52 : 480));
    assign line_i = !(drv_low_o || slave_low);

    always @(negedge clk) begin
        if (drv_low_o) begin
            if (lowcnt == 0)
                hold <= sl_pat[(slots - sl_base) & 7] ? 0 : (sl_od ? 16 : 120);
            else if (hold != 0)
                hold <= hold - 1;
            lowcnt <= lowcnt + 1;
        end else begin
            if (hold != 0) hold <= hold - 1;
            if (lowcnt != 0) begin
                last_low <= lowcnt;
                lowcnt   <= 0;
                if (lowcnt > (sl_od ? 100 : 1000)) begin
                    prs     <= sl_present;
                    prs_cnt <= 0;
                end else begin
                    slots <= slots + 1;
                    rx    <= {(lowcnt < (sl_od ? 16 : 60)), rx[7:1]};
                end
            end
        end
        if (prs) prs_cnt <= prs_cnt + 1;
        if (prs && prs_cnt > 600) prs <= 1'b0;
        if (apu_en_o) apu_cyc <= apu_cyc + 1;
        if (drv_low_o && (apu_en_o || spu_en_o)) overlap <= overlap + 1;
    end

    ow_seq u0 (
        .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .cmd_valid_i(cmd_valid_i),
        .cmd_i(cmd_i), .wdata_i(wdata_i), .speed_od_i(speed_od_i), .apu_i(apu_i),
        .spu_i(spu_i), .ppm_i(ppm_i), .line_i(line_i), .drv_low_o(drv_low_o),
        .apu_en_o(apu_en_o), .spu_en_o(spu_en_o), .busy_o(busy_o),
        .presence_o(presence_o), .short_o(short_o), .bit_o(bit_o), .cmp_o(cmp_o),
        .dir_o(dir_o), .rdata_o(rdata_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [2:0] c, input logic [7:0] w, input logic od,
                          input logic apu, input logic spu, input logic ppm);
        @(negedge clk);
        sl_od = od; sl_base = slots;
        cmd_i = c; wdata_i = w; speed_od_i = od; apu_i = apu; spu_i = spu; ppm_i = ppm;
        cmd_valid_i = 1'b1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic run(input logic [2:0] c, input logic [7:0] w, input logic od,
                       input logic apu, input logic spu, input logic ppm);
        strobe(c, w, od, apu, spu, ppm);
        while (busy_o) @(negedge clk);
    endtask

    task automatic t_reset_state;
        check(!busy_o && !drv_low_o && !presence_o && !short_o && !spu_en_o && !apu_en_o,
              "R1 reset state", {busy_o, drv_low_o, presence_o, short_o, spu_en_o, apu_en_o}, 0);
    endtask

    task automatic t_bus_reset;
        sl_present = 1'b1;
        run(3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        check(last_low >= 479*4 && last_low <= 480*4, "R1 std reset low clocks", last_low, 480*4);
        check(presence_o == 1'b1, "R2 presence std", presence_o, 1);
        run(3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        check(last_low >= 47*4 && last_low <= 48*4, "R9 od reset low clocks", last_low, 48*4);
        check(presence_o == 1'b1, "R9 presence od", presence_o, 1);
        run(3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        check(presence_o == 1'b0, "R3 masked presence", presence_o, 0);
        sl_present = 1'b0;
        run(3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        check(presence_o == 1'b0 && short_o == 1'b0, "R2 no device", {presence_o, short_o}, 0);
        sl_present = 1'b1;
        strobe(3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        while (drv_low_o) @(negedge clk);
        sl_short = 1'b1;
        while (busy_o) @(negedge clk);
        check(short_o == 1'b1 && presence_o == 1'b0, "R4 short", {short_o, presence_o}, 2);
        sl_short = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_write_byte;
        int s0;
        sl_pat = 8'hFF;
        s0 = slots;
        run(3'd1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
        check(rx == 8'hA5 && slots - s0 == 8, "R5 write A5 std", rx, 8'hA5);
        run(3'd1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0);
        check(rx == 8'h3C, "R9 write 3C od", rx, 8'h3C);
    endtask

    task automatic t_read_byte;
        sl_pat = 8'h96;
        run(3'd2, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        check(rdata_o == 8'h96, "R6 read std", rdata_o, 8'h96);
        check(rx == 8'hFF, "R6 read slots are 1-slots", rx, 8'hFF);
        sl_pat = 8'h5A;
        run(3'd2, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        check(rdata_o == 8'h5A, "R9 read od", rdata_o, 8'h5A);
    endtask

    task automatic t_single_bit;
        sl_pat = 8'hFF;
        run(3'd3, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        check(rx[7] == 1'b0 && bit_o == 1'b0, "R7 write 0", {rx[7], bit_o}, 0);
        run(3'd3, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
        check(rx[7] == 1'b1 && bit_o == 1'b1, "R7 read 1", {rx[7], bit_o}, 3);
        sl_pat = 8'hFE;
        run(3'd3, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
        check(bit_o == 1'b0, "R7 read 0", bit_o, 0);
    endtask

    task automatic trip(input logic id, input logic cp, input logic hd, input logic exp_dir);
        sl_pat = {5'b11111, 1'b1, cp, id};
        run(3'd4, {7'd0, hd}, 1'b0, 1'b0, 1'b0, 1'b0);
        check(bit_o == id && cmp_o == cp, "R8 triplet reads", {bit_o, cmp_o}, {id, cp});
        check(dir_o == exp_dir && rx[7] == exp_dir, "R8 triplet direction", {dir_o, rx[7]}, {exp_dir, exp_dir});
    endtask

    task automatic t_triplet;
        trip(1'b0, 1'b1, 1'b1, 1'b0);
        trip(1'b1, 1'b0, 1'b0, 1'b1);
        trip(1'b0, 1'b0, 1'b1, 1'b1);
        trip(1'b0, 1'b0, 1'b0, 1'b0);
        trip(1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_strong_pullup;
        sl_pat = 8'hFF;
        run(3'd1, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b0);
        check(spu_en_o == 1'b1, "R10 spu after write", spu_en_o, 1);
        repeat (20) @(negedge clk);
        check(spu_en_o == 1'b1, "R10 spu held", spu_en_o, 1);
        strobe(3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        check(spu_en_o == 1'b0 && drv_low_o == 1'b1, "R10 spu ends at next command", spu_en_o, 0);
        while (busy_o) @(negedge clk);
        run(3'd2, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        check(spu_en_o == 1'b0, "R10 no spu after read", spu_en_o, 0);
        run(3'd1, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0);
        check(spu_en_o == 1'b0, "R10 no spu without request", spu_en_o, 0);
    endtask

    task automatic t_active_pullup;
        int a0;
        a0 = apu_cyc;
        run(3'd1, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        check(apu_cyc - a0 >= 8*7 && apu_cyc - a0 <= 8*9, "R11 apu cycles", apu_cyc - a0, 64);
        check(overlap == 0, "R11 no overlap", overlap, 0);
        a0 = apu_cyc;
        run(3'd1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0);
        check(apu_cyc == a0, "R11 apu off", apu_cyc - a0, 0);
    endtask

    task automatic t_busy_ignore;
        int s0;
        s0 = slots;
        sl_present = 1'b1;
        strobe(3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        strobe(3'd1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        while (busy_o) @(negedge clk);
        repeat (1000) @(negedge clk);
        check(slots == s0 && !busy_o, "R12 command during busy ignored", slots - s0, 0);
        check(last_low >= 479*4, "R12 reset kept its speed", last_low, 480*4);
        strobe(3'd5, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        check(!busy_o && !drv_low_o, "R12 bad code ignored", busy_o, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_ni = 1'b1;
        repeat (5) @(negedge clk);
        t_reset_state();
        t_bus_reset();
        t_write_byte();
        t_read_byte();
        t_single_bit();
        t_triplet();
        t_strong_pullup();
        t_active_pullup();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule